// File: doc/BRIEF.md
# Buffered SPI Slave Transceiver

This block is one SPI slave channel that runs full duplex without gaps between bytes. Software and the serial side share one data register. Software writes the next outgoing byte into it while the current byte is still shifting. When a byte completes, the byte received on SI replaces the register contents, so software reads it from the same place. A buffer-full flag shows when the register holds a transmit byte that has not yet been consumed. A busy flag shows that a byte is shifting.

The external SCK and SI pins are brought into the system clock through two-flop synchronisers. Edges are then detected on the synchronised clock, so the system clock must run at least four times faster than SCK. SCK idles high. SO changes on falling edges and SI is sampled on rising edges, most significant bit first, eight bits per byte.

A mode bit selects when the interrupt pulse fires:
- a buffer-empty event, which suits streaming;
- the end of a byte, which suits the last byte of a message.

The mode bit may change while a byte is shifting. If the data register is empty when a new byte has to start, the channel sends the last loaded byte again and sets a sticky underrun flag.

Top module: `spi_slave_buf`

## Requirements
- R1: Each byte moves eight bits at once in both directions, MSB first. A master clocking a byte receives the transmit byte that was loaded. About three system clocks after the eighth rising SCK edge, `rd_data` holds the byte the master drove on SI.
- R2: A bus write (`wr_en` high for one cycle) sets `buf_full`. A write while `buf_full` is 1 silently replaces the pending byte, and the newest value is the one transmitted. `buf_full` clears when the pending byte moves into the shift register.
- R3: `rd_data` always shows the data register: the pending transmit byte while one is waiting, and otherwise the last received byte. Observing it never disturbs a transfer.
- R4: SCK idles high. SO changes only after a synchronised falling SCK edge, and SI is captured on rising edges.
- R5: `busy` rises at the first falling SCK edge of a byte and falls after the eighth rising edge, unless a pending byte exists. In that case the next byte loads with no gap and `busy` stays high.
- R6: With `irq_mode` = 1 (buffer-empty), `irq` pulses for one cycle each time a pending byte moves into the shift register.
- R7: With `irq_mode` = 0 (transfer-end), `irq` pulses for one cycle when a byte's last bit completes. The mode is taken at that moment, so a change made before the last bit applies to that byte.
- R8: A byte that starts with `buf_full` = 0 resends the last loaded byte, which is 0x00 after reset or disable, and sets the sticky `underrun` flag.
- R9: While `en` is low, all of the following hold:
  - `busy`, `buf_full`, `underrun`, `irq`, `so` and `rd_data` are 0;
  - the shift state is cleared;
  - bus writes and SCK edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low clears the channel |
| wr_en | input | 1 | One-cycle write strobe for the data register |
| wr_data | input | 8 | Transmit byte to write |
| irq_mode | input | 1 | 1 = buffer-empty interrupt, 0 = transfer-end interrupt |
| rd_data | output | 8 | Data register contents |
| buf_full | output | 1 | A transmit byte is pending |
| busy | output | 1 | A byte is shifting |
| underrun | output | 1 | Sticky: a byte started with an empty register |
| irq | output | 1 | One-cycle interrupt pulse |
| sck | input | 1 | Serial clock from the master, idle high |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |

## Verification
The assertions watch properties that hold on every cycle:
- the interrupt is a single-cycle pulse;
- `buf_full` rises only after a bus write;
- SO moves only after a detected falling SCK edge;
- the underrun flag is sticky;
- disable clears the flags;
- when `busy` drops in transfer-end mode, an interrupt fires alongside it.

Byte contents, the overwrite rule, gap-free chaining of two bytes, resending on underrun and a mode change part-way through a byte can only be shown by the bench's scenarios. There a master drives SCK and SI and the received bytes are compared with a cycle-level reference model.

// File: rtl/spi_sb_pkg.sv
package spi_sb_pkg;
  typedef enum logic {
    IRQ_XFER_END  = 1'b0,
    IRQ_BUF_EMPTY = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/spi_sb_sync.sv
module spi_sb_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_sb_shifter.sv
module spi_sb_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sck_fall,
  input  logic          sck_rise,
  input  logic          si_s,
  input  logic          buf_full,
  input  logic [DW-1:0] pend,
  output logic          so,
  output logic          busy,
  output logic          take,
  output logic          done,
  output logic          start_empty,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [DW-1:0] sh;
  logic [DW-1:0] last_tx;
  logic [CW-1:0] cnt;
  logic          start;

  assign start       = sck_fall && !busy;
  assign done        = sck_rise && busy && (cnt == LAST_BIT);
  assign take        = (start || done) && buf_full;
  assign start_empty = start && !buf_full;
  assign rx_byte     = {sh[DW-2:0], si_s};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh      <= '0;
      last_tx <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      so      <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      if (buf_full) begin
        sh      <= pend;
        last_tx <= pend;
        so      <= pend[DW-1];
      end else begin
        sh <= last_tx;
        so <= last_tx[DW-1];
      end
    end else if (sck_fall) begin
      so <= sh[DW-1];
    end else if (sck_rise && busy) begin
      if (done) begin
        cnt <= '0;
        if (buf_full) begin
          sh      <= pend;
          last_tx <= pend;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        sh  <= rx_byte;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_sb_dreg.sv
module spi_sb_dreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] dreg,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      dreg <= '0;
      full <= 1'b0;
    end else begin
      if (done) dreg <= rx_byte;
      if (take) full <= 1'b0;
      if (wr_en) begin
        dreg <= wr_data;
        full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_mode,
  output logic [DW-1:0] rd_data,
  output logic          buf_full,
  output logic          busy,
  output logic          underrun,
  output logic          irq,
  input  logic          sck,
  input  logic          si,
  output logic          so
);
  import spi_sb_pkg::*;

  logic [1:0]    pins_s;
  logic          sck_s, si_s, sck_d;
  logic          sck_fall, sck_rise;
  logic          take, done, start_empty;
  logic [DW-1:0] rx_byte;
  irq_mode_e     mode;

  assign mode = irq_mode_e'(irq_mode);

  spi_sb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .d({si, sck}), .q(pins_s)
  );
  assign sck_s = pins_s[0];
  assign si_s  = pins_s[1];

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b1;
    else     sck_d <= sck_s;
  end
  assign sck_fall = sck_d && !sck_s;
  assign sck_rise = !sck_d && sck_s;

  spi_sb_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .en(en), .sck_fall(sck_fall), .sck_rise(sck_rise),
    .si_s(si_s), .buf_full(buf_full), .pend(rd_data), .so(so), .busy(busy),
    .take(take), .done(done), .start_empty(start_empty), .rx_byte(rx_byte)
  );

  spi_sb_dreg #(.DW(DW)) u_dreg (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .done(done), .rx_byte(rx_byte), .dreg(rd_data), .full(buf_full)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      irq      <= 1'b0;
      underrun <= 1'b0;
    end else begin
      irq <= (take && mode == IRQ_BUF_EMPTY) || (done && mode == IRQ_XFER_END);
      if (start_empty) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic wr_en,
  input logic irq_mode,
  input logic buf_full,
  input logic busy,
  input logic underrun,
  input logic irq,
  input logic so,
  input logic sck_fall
);
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
  // R2
  full_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> $past(wr_en && en));
  // R4
  so_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(so) && $past(en)) |-> $past(sck_fall));
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && en) |=> underrun);
  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy && !buf_full && !underrun && !irq));
  // R7
  end_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(en) && !$past(irq_mode)) |-> irq);
endmodule

bind spi_slave_buf spi_slave_buf_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .irq_mode(irq_mode),
  .buf_full(buf_full), .busy(busy), .underrun(underrun), .irq(irq),
  .so(so), .sck_fall(sck_fall)
);

// File: tb/sim_spi_slave_buf.sv
`timescale 1ns/1ps
module sim_spi_slave_buf;
  localparam int H = 4;
  logic clk = 0, rst = 1, en = 0, wr_en = 0, irq_mode = 0, sck = 1, si = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic buf_full, busy, underrun, irq, so;
  int checks = 0, errs = 0, irq_cnt = 0, busy_falls = 0;
  logic prev_busy = 0;

  always #2 clk = ~clk;

  spi_slave_buf u0 (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .irq_mode(irq_mode), .rd_data(rd_data), .buf_full(buf_full), .busy(busy),
    .underrun(underrun), .irq(irq), .sck(sck), .si(si), .so(so)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model
  logic hs[3];
  logic hi[3];
  logic [7:0] m_sh, m_last, m_d, rxb;
  logic m_so, m_busy, m_full, m_irq, m_unr, fall, rise, sid, tk, dn;
  int m_bits;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin hs[i] = 1; hi[i] = 0; end
      m_sh = 0; m_last = 0; m_d = 0; m_so = 0; m_busy = 0; m_full = 0;
      m_irq = 0; m_unr = 0; m_bits = 0;
    end else begin
      fall = hs[2] && !hs[1];
      rise = !hs[2] && hs[1];
      sid  = hi[1];
      if (!en) begin
        m_sh = 0; m_last = 0; m_d = 0; m_so = 0; m_busy = 0; m_full = 0;
        m_irq = 0; m_unr = 0; m_bits = 0;
      end else begin
        tk = 0; dn = 0;
        rxb = {m_sh[6:0], sid};
        if (fall && !m_busy) begin
          m_busy = 1; m_bits = 0;
          if (m_full) begin m_sh = m_d; m_last = m_d; tk = 1; end
          else begin m_sh = m_last; m_unr = 1; end
          m_so = m_sh[7];
        end else if (fall) begin
          m_so = m_sh[7];
        end else if (rise && m_busy) begin
          if (m_bits == 7) begin
            dn = 1; m_bits = 0;
            if (m_full) begin m_sh = m_d; m_last = m_d; tk = 1; end
            else m_busy = 0;
          end else begin
            m_sh = rxb; m_bits++;
          end
        end
        if (dn) m_d = rxb;
        m_irq = (tk && irq_mode) || (dn && !irq_mode);
        if (tk) m_full = 0;
        if (wr_en) begin m_d = wr_data; m_full = 1; end
      end
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = sck;
      hi[2] = hi[1]; hi[1] = hi[0]; hi[0] = si;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 so", so, m_so);
      chk("R6/R7 irq", irq, m_irq);
      chk("R2 buf_full", buf_full, m_full);
      chk("R5 busy", busy, m_busy);
      chk("R8 underrun", underrun, m_unr);
      chk("R3 rd_data", rd_data, m_d);
    end
  end

  always @(posedge clk) begin
    if (irq) irq_cnt++;
    if (prev_busy && !busy) busy_falls++;
    prev_busy = busy;
  end

  task automatic wr(input logic [7:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic xfer(input logic [7:0] mtx, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sck = 0; si = mtx[i];
      repeat (H) @(negedge clk);
      got[i] = so; sck = 1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic [7:0] g1, g2;
    int ic, bf;
    repeat (4) @(negedge clk);
    rst = 0; en = 1;
    @(negedge clk);
    chk("R9 reset rd_data", rd_data, 8'h00);
    chk("R9 reset flags", {busy, buf_full, underrun, irq}, 4'b0000);

    // A: transfer-end mode, single byte
    irq_mode = 0;
    wr(8'hA5);
    chk("R2 full after write", buf_full, 1'b1);
    chk("R3 pending readback", rd_data, 8'hA5);
    ic = irq_cnt;
    xfer(8'h3C, g1); settle();
    chk("R1 master got tx", g1, 8'hA5);
    chk("R1 rx in rd_data", rd_data, 8'h3C);
    chk("R7 one end irq", irq_cnt - ic, 1);
    chk("R5 idle after byte", busy, 1'b0);

    // B: overwrite while full
    wr(8'h11); wr(8'h22);
    chk("R2 overwrite readback", rd_data, 8'h22);
    xfer(8'h5A, g1); settle();
    chk("R2 newest byte sent", g1, 8'h22);
    chk("R1 rx 5A", rd_data, 8'h5A);

    // C: buffer-empty mode, two chained bytes
    irq_mode = 1;
    wr(8'h81);
    ic = irq_cnt; bf = busy_falls;
    fork
      begin xfer(8'hF0, g1); xfer(8'h0F, g2); end
      begin
        do @(negedge clk); while (!irq);
        wr(8'h7E);
      end
    join
    settle();
    chk("R1 first chained", g1, 8'h81);
    chk("R5 second chained", g2, 8'h7E);
    chk("R5 single busy drop", busy_falls - bf, 1);
    chk("R6 two load irqs", irq_cnt - ic, 2);
    chk("R1 rx 0F", rd_data, 8'h0F);
    chk("R8 no underrun yet", underrun, 1'b0);

    // D: underrun resends last loaded
    xfer(8'h99, g1); settle();
    chk("R8 resend last", g1, 8'h7E);
    chk("R8 sticky set", underrun, 1'b1);

    // E: mode change mid-byte
    wr(8'h33);
    ic = irq_cnt;
    fork
      xfer(8'h66, g1);
      begin repeat (H * 6) @(negedge clk); irq_mode = 0; end
    join
    settle();
    chk("R7 load and end irq", irq_cnt - ic, 2);
    chk("R1 sent 33", g1, 8'h33);

    // F: disable
    en = 0;
    repeat (2) @(negedge clk);
    chk("R9 cleared flags", {busy, buf_full, underrun, irq}, 4'b0000);
    chk("R9 cleared data", rd_data, 8'h00);
    wr(8'h44);
    chk("R9 write ignored", buf_full, 1'b0);
    xfer(8'h55, g1); settle();
    chk("R9 edges ignored", {busy, rd_data}, 9'h000);
    en = 1;
    @(negedge clk);
    xfer(8'hC3, g1); settle();
    chk("R8 zero after disable", g1, 8'h00);
    chk("R8 underrun again", underrun, 1'b1);
    chk("R1 rx C3", rd_data, 8'hC3);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule